// File: doc/BRIEF.md
# Level-Request Block Transfer DMA Sequencer

This block is one DMA channel driven by an active-low, level-sensitive request pin. Software starts it with a single configuration write. That write carries the source and destination start addresses, the number of units in each block and the number of blocks. On the clock edge after that write, the channel begins watching the request pin.

A low level seen on any sampling edge sets an internal pending flag. The flag is cleared when the channel activates at the next bus break. On activation the channel raises a bus request and waits for a grant. It then moves one block: each unit is a read from the source address followed by a write of that data to the destination address. Both addresses advance by one unit after each access, and they carry on across blocks.

After the final write of a block, one dead cycle follows. Only then does the channel watch the pin again. When the last block's dead cycle ends, a one-cycle done pulse is produced and the channel switches itself off.

Top module: `dma_blk_seq`

## Requirements
- R1: After reset, bus_req, m_rd, m_wr and done are all low, and the channel is off.
- R2: A cfg_we pulse while the channel is off, with nonzero cfg_blk_size and cfg_blk_cnt, turns the channel on. The request pin is first sampled on the clock edge after the edge that ends the write cycle. A low level present only during the write cycle starts nothing.
- R3: While acceptance is open, a low level of req_n on one sampling edge is held. bus_req rises in the cycle after the next edge, even if req_n has already returned high.
- R4: bus_req stays high for at least 2 cycles before the first read of a block. No read starts until bus_gnt is seen high, and m_rd and m_wr are only active while bus_req is high.
- R5: A block is cfg_blk_size pairs of accesses: a read (m_rd) at the source address, then a write (m_wr) at the destination address of the data just read. Each address advances by DW/8 (4 by default) after its access, and the addresses continue from block to block.
- R6: Exactly one dead cycle follows the last write of a block. In that cycle bus_req is high and m_rd and m_wr are low, and bus_req then drops.
- R7: Acceptance is closed from activation until the dead cycle ends. A low pulse on req_n confined to that window starts no further block.
- R8: When req_n stays low throughout, bus_req is low for exactly 2 cycles between consecutive blocks.
- R9: done is high for exactly one cycle, in the cycle after the last block's dead cycle, with bus_req low. The channel is then off, and req_n low starts nothing.
- R10: A cfg_we pulse while the channel is on has no effect on the addresses, block size or block count in use.
- R11: A cfg_we pulse with cfg_blk_size of 0 or cfg_blk_cnt of 0 leaves the channel off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe that also enables the channel |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_blk_size | input | SZW | Units per block |
| cfg_blk_cnt | input | CW | Number of blocks |
| req_n | input | 1 | Transfer request, active low, level sensitive |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| m_addr | output | AW | Bus address |
| m_rd | output | 1 | Read strobe; m_rdata is taken in the same cycle |
| m_wr | output | 1 | Write strobe |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data |
| done | output | 1 | One-cycle pulse when all blocks are finished |

## Verification
Two events can share a cycle: the request pin capturing a new low level, and the activation that clears the held request. Activation fires in the one cycle where the pin is still low and acceptance is still open. The bench provokes this by holding req_n low across several blocks. It judges the result by counting requests that survive: exactly one block must follow each activation, and the gap between blocks must be exactly two cycles, not zero or one. A second overlap is a configuration write arriving while blocks are in flight. This is judged by the scoreboard, which finds every address and data word unchanged.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_ARB,
        ST_RD,
        ST_WR,
        ST_DEAD
    } seq_st_e;

endpackage

// File: rtl/dma_req_sampler.sv
module dma_req_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic clr_i,
    input  logic req_n_i,
    output logic held_o
);

    logic held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (clr_i) begin
            held_d = 1'b0;
        end else if (open_i && !req_n_i) begin
            held_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else begin
            held_q <= held_d;
        end
    end

    assign held_o = held_q;

    AST_HELD_DROPS_ON_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !held_o); // R3

    AST_CAPTURE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_o) |-> ($past(open_i) && !$past(req_n_i))); // R3

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] rdata_i,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [DW-1:0] data_o
);

    localparam int UNIT = DW / 8;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [DW-1:0] data;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (load_i) begin
            dp_d.src = src_i;
            dp_d.dst = dst_i;
        end
        if (rd_i) begin
            dp_d.data = rdata_i;
            dp_d.src  = dp_q.src + AW'(UNIT);
        end
        if (wr_i) begin
            dp_d.dst = dp_q.dst + AW'(UNIT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign src_o  = dp_q.src;
    assign dst_o  = dp_q.dst;
    assign data_o = dp_q.data;

    AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !load_i) |=> (src_o - $past(src_o)) == AW'(UNIT)); // R5

    AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !load_i) |=> (dst_o - $past(dst_o)) == AW'(UNIT)); // R5

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_blk_pkg::*;
#(
    parameter int SZW = 8,
    parameter int CW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we_i,
    input  logic [SZW-1:0] blk_size_i,
    input  logic [CW-1:0]  blk_cnt_i,
    input  logic           held_i,
    input  logic           gnt_i,
    output logic           open_o,
    output logic           clr_o,
    output logic           load_o,
    output logic           bus_req_o,
    output logic           rd_o,
    output logic           wr_o,
    output logic           done_o,
    output seq_st_e        state_o
);

    typedef struct packed {
        seq_st_e        st;
        logic           arb;
        logic [SZW-1:0] units;
        logic [SZW-1:0] size;
        logic [CW-1:0]  blks;
        logic           done;
    } fsm_t;

    fsm_t f_d, f_q;
    logic cfg_ok;

    assign cfg_ok = (f_q.st == ST_OFF) && cfg_we_i
                    && (blk_size_i != '0) && (blk_cnt_i != '0);

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        unique case (f_q.st)
            ST_OFF: begin
                if (cfg_ok) begin
                    f_d.st   = ST_IDLE;
                    f_d.size = blk_size_i;
                    f_d.blks = blk_cnt_i;
                end
            end
            ST_IDLE: begin
                f_d.arb = 1'b0;
                if (held_i) begin
                    f_d.st = ST_ARB;
                end
            end
            ST_ARB: begin
                f_d.arb = 1'b1;
                if (gnt_i && f_q.arb) begin
                    f_d.st    = ST_RD;
                    f_d.units = f_q.size;
                end
            end
            ST_RD: begin
                f_d.st = ST_WR;
            end
            ST_WR: begin
                if (f_q.units == SZW'(1)) begin
                    f_d.st = ST_DEAD;
                end else begin
                    f_d.units = f_q.units - SZW'(1);
                    f_d.st    = ST_RD;
                end
            end
            ST_DEAD: begin
                if (f_q.blks == CW'(1)) begin
                    f_d.st   = ST_OFF;
                    f_d.done = 1'b1;
                end else begin
                    f_d.blks = f_q.blks - CW'(1);
                    f_d.st   = ST_IDLE;
                end
            end
            default: f_d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '{st: ST_OFF, arb: 1'b0, units: '0, size: '0, blks: '0, done: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign open_o    = (f_q.st == ST_IDLE);
    assign clr_o     = (f_q.st == ST_IDLE) && held_i;
    assign load_o    = cfg_ok;
    assign bus_req_o = (f_q.st == ST_ARB) || (f_q.st == ST_RD)
                       || (f_q.st == ST_WR) || (f_q.st == ST_DEAD);
    assign rd_o      = (f_q.st == ST_RD);
    assign wr_o      = (f_q.st == ST_WR);
    assign done_o    = f_q.done;
    assign state_o   = f_q.st;

    AST_ARB_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_RD && $past(f_q.st) == ST_ARB) |-> $past(f_q.st, 2) == ST_ARB); // R4

    AST_READ_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_RD && $past(f_q.st) == ST_ARB) |-> $past(gnt_i)); // R4

    AST_DEAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_DEAD) |-> $past(f_q.st) == ST_WR); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_BUSY_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st != ST_OFF) |=> (f_q.size == $past(f_q.size))); // R10

    AST_ZERO_CFG_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_OFF && cfg_we_i && (blk_size_i == '0 || blk_cnt_i == '0))
        |=> f_q.st == ST_OFF); // R11

endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
    import dma_blk_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int SZW = 8,
    parameter int CW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    input  logic [SZW-1:0] cfg_blk_size,
    input  logic [CW-1:0]  cfg_blk_cnt,
    input  logic           req_n,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic [AW-1:0]  m_addr,
    output logic           m_rd,
    output logic           m_wr,
    output logic [DW-1:0]  m_wdata,
    input  logic [DW-1:0]  m_rdata,
    output logic           done
);

    logic          open_w, clr_w, held_w, load_w;
    logic [AW-1:0] src_w, dst_w;
    seq_st_e       state_w;

    dma_req_sampler u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_i  (open_w),
        .clr_i   (clr_w),
        .req_n_i (req_n),
        .held_o  (held_w)
    );

    dma_seq_fsm #(.SZW(SZW), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we),
        .blk_size_i (cfg_blk_size),
        .blk_cnt_i  (cfg_blk_cnt),
        .held_i     (held_w),
        .gnt_i      (bus_gnt),
        .open_o     (open_w),
        .clr_o      (clr_w),
        .load_o     (load_w),
        .bus_req_o  (bus_req),
        .rd_o       (m_rd),
        .wr_o       (m_wr),
        .done_o     (done),
        .state_o    (state_w)
    );

    dma_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .src_i   (cfg_src),
        .dst_i   (cfg_dst),
        .rd_i    (m_rd),
        .wr_i    (m_wr),
        .rdata_i (m_rdata),
        .src_o   (src_w),
        .dst_o   (dst_w),
        .data_o  (m_wdata)
    );

    assign m_addr = m_rd ? src_w : (m_wr ? dst_w : '0);

    AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_w) |-> $past(state_w) == ST_IDLE); // R7

    AST_MASTER_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_rd, m_wr}) && ((m_rd || m_wr) -> bus_req)); // R4

endmodule

// File: tb/sim_dma_blk_seq.sv
module sim_dma_blk_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_src = '0;
    logic [31:0] cfg_dst = '0;
    logic [7:0]  cfg_blk_size = '0;
    logic [7:0]  cfg_blk_cnt = '0;
    logic        req_n = 1'b1;
    logic        bus_gnt = 1'b0;
    logic        bus_req, m_rd, m_wr, done;
    logic [31:0] m_addr, m_wdata, m_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] rdq[$];
    logic [63:0] wrq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] memf(logic [31:0] a);
        return (a << 3) ^ 32'hC3A5_0F1E ^ {a[15:0], a[31:16]};
    endfunction

    assign m_rdata = memf(m_addr);

    dma_blk_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .cfg_blk_size(cfg_blk_size), .cfg_blk_cnt(cfg_blk_cnt),
        .req_n(req_n), .bus_req(bus_req), .bus_gnt(bus_gnt), .m_addr(m_addr),
        .m_rd(m_rd), .m_wr(m_wr), .m_wdata(m_wdata), .m_rdata(m_rdata), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] s, input logic [31:0] d,
                             input int sz, input int cnt, input bit push);
        @(negedge clk);
        cfg_we = 1'b1; cfg_src = s; cfg_dst = d;
        cfg_blk_size = 8'(sz); cfg_blk_cnt = 8'(cnt);
        if (push) begin
            for (int k = 0; k < sz * cnt; k++) begin
                rdq.push_back(s + 32'(4 * k));
                wrq.push_back({d + 32'(4 * k), memf(s + 32'(4 * k))});
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // monitor: compares every bus access against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_rd) begin
                if (rdq.size() == 0) chk(1'b0, "R5 unexpected read", 64'(m_addr), 64'hFFFF);
                else begin
                    logic [31:0] e;
                    e = rdq.pop_front();
                    chk(m_addr == e, "R5 read address", 64'(m_addr), 64'(e));
                end
            end
            if (m_wr) begin
                if (wrq.size() == 0) chk(1'b0, "R5 unexpected write", 64'(m_addr), 64'hFFFF);
                else begin
                    logic [63:0] e;
                    e = wrq.pop_front();
                    chk({m_addr, m_wdata} == e, "R5 R10 write address and data",
                        {m_addr, m_wdata}, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", 64'h0, 64'h1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int gaps, lowcnt;
        bit seen, got_done;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({bus_req, m_rd, m_wr, done} == 4'b0, "R1 reset outputs",
            64'({bus_req, m_rd, m_wr, done}), 64'h0);

        // R2: low level present only during the enable write is not captured
        req_n = 1'b0;
        cfg_write(32'h100, 32'h200, 2, 1, 1'b1);
        req_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!bus_req, "R2 no capture from write cycle", 64'(bus_req), 64'h0);
        end
        // R3: one-edge pulse is held
        req_n = 1'b0;
        @(negedge clk);
        req_n = 1'b1;
        chk(!bus_req, "R3 not yet active", 64'(bus_req), 64'h0);
        @(negedge clk);
        chk(bus_req, "R3 held request activates", 64'(bus_req), 64'h1);
        // R4: no read without grant
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(bus_req && !m_rd, "R4 wait for grant", 64'({bus_req, m_rd}), 64'h2);
        end
        bus_gnt = 1'b1;
        @(negedge clk);
        chk(m_rd, "R4 read after grant", 64'(m_rd), 64'h1);
        repeat (3) @(negedge clk);
        chk(m_wr, "R5 second write", 64'(m_wr), 64'h1);
        @(negedge clk);
        chk({bus_req, m_rd, m_wr} == 3'b100, "R6 dead cycle",
            64'({bus_req, m_rd, m_wr}), 64'h4);
        @(negedge clk);
        chk(done && !bus_req, "R9 done after dead", 64'({done, bus_req}), 64'h2);
        @(negedge clk);
        chk(!done, "R9 done one cycle", 64'(done), 64'h0);
        req_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!bus_req, "R9 channel off after done", 64'(bus_req), 64'h0);
        end
        req_n = 1'b1;

        // R8 and R10: level held low, several blocks, busy cfg write
        req_n = 1'b0;
        cfg_write(32'h1000, 32'h2000, 3, 3, 1'b1);
        gaps = 0; lowcnt = 0; seen = 1'b0; got_done = 1'b0;
        for (int i = 0; i < 200 && !got_done; i++) begin
            @(negedge clk);
            if (done) got_done = 1'b1;
            else if (bus_req) begin
                if (seen && lowcnt > 0) begin
                    chk(lowcnt == 2, "R8 gap between blocks", 64'(lowcnt), 64'h2);
                    gaps++;
                end
                seen = 1'b1; lowcnt = 0;
            end else if (seen) lowcnt++;
            cfg_we = (i == 6);
            if (i == 6) begin
                cfg_src = 32'hF000; cfg_dst = 32'hE000;
                cfg_blk_size = 8'd1; cfg_blk_cnt = 8'd9;
            end
        end
        cfg_we = 1'b0;
        req_n = 1'b1;
        chk(got_done, "R9 done after three blocks", 64'(got_done), 64'h1);
        chk(gaps == 2, "R8 gap count", 64'(gaps), 64'h2);

        // R7: pulse inside transfer window is dropped
        cfg_write(32'h3000, 32'h4000, 1, 2, 1'b1);
        req_n = 1'b0;
        @(negedge clk);
        req_n = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (m_rd) seen = 1'b1;
        end
        chk(seen, "R3 block started", 64'(seen), 64'h1);
        req_n = 1'b0;
        @(negedge clk);
        req_n = 1'b1;
        @(negedge clk);
        chk({bus_req, m_rd, m_wr} == 3'b100, "R6 dead after single unit",
            64'({bus_req, m_rd, m_wr}), 64'h4);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!bus_req, "R7 pulse during transfer ignored", 64'(bus_req), 64'h0);
        end
        req_n = 1'b0;
        @(negedge clk);
        req_n = 1'b1;
        got_done = 1'b0;
        for (int i = 0; i < 30 && !got_done; i++) begin
            @(negedge clk);
            if (done) got_done = 1'b1;
        end
        chk(got_done, "R9 second block completes", 64'(got_done), 64'h1);

        // R11: zero size or zero count leaves channel off
        req_n = 1'b0;
        cfg_write(32'h5000, 32'h6000, 0, 1, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!bus_req, "R11 zero size ignored", 64'(bus_req), 64'h0);
        end
        cfg_write(32'h5000, 32'h6000, 2, 0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!bus_req, "R11 zero count ignored", 64'(bus_req), 64'h0);
        end
        req_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(rdq.size() == 0 && wrq.size() == 0, "R5 all accesses seen",
            64'(rdq.size() + wrq.size()), 64'h0);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule